// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken, using only the branch's fetch address. It holds two independent direction predictors and a chooser. The first predictor keeps a short private outcome history for each branch slot and uses that history to pick a saturating counter. The second predictor uses one shared history of the most recent outcomes across all branches to pick a counter from its own table. For each branch slot, a 2-bit chooser counter decides which of the two answers is passed on as the final direction.

A lookup is combinational. In the same cycle, the block returns the final direction, both component guesses and the two history values used to form them. The fetch side keeps these values next to the branch. When the branch resolves, it sends them back on the update port together with the real outcome. Training therefore uses the table slots that produced the guess, even if the histories have moved on since then. A lookup and an update may occur in the same cycle. The lookup then sees the state from before that update.

Both directions are plain valid-qualified transfers with no back-pressure. Every lookup is answered in the cycle it is presented, and every update is absorbed at the next clock edge. The block therefore has no ready signals.

Top module: `tourney_bp`

## Requirements
- R1: After reset, all history bits read 0, every direction counter holds 01 (weak not-taken) and every chooser counter holds 01 (weak local), so every lookup returns taken=0, local=0, global=0, lhist=000, ghist=000.
- R2: The per-branch history table and the chooser are selected by PC bits [4:2] only. Lookups whose PCs differ only outside those bits give identical outputs.
- R3: The local guess is bit 1 of the local counter that is selected by the 3-bit history currently stored for the looked-up branch slot.
- R4: The global guess is bit 1 of the global counter that is selected by the 3-bit global history register.
- R5: The final direction is the global guess when bit 1 of the slot's chooser counter is 1, and the local guess when it is 0. When the two guesses agree, the final direction equals both.
- R6: Direction counters are 2-bit and saturating, with 00 meaning strongly not-taken and 11 meaning strongly taken. On an update, the counter moves up one step on taken and down one step on not-taken, and stays put at 11 or 00.
- R7: On an update, the outcome (1 = taken) is shifted into bit 0 of the updated branch slot's history: new = {old[1:0], taken}.
- R8: On an update, the global history becomes {old[1:0], taken}. Without an update, it holds.
- R9: The chooser counter of the updated slot changes only when the returned local and global guesses differ. It moves one step toward 11 if the global guess matched the outcome, and toward 00 otherwise, saturating at both ends.
- R10: Outputs are valid in the same cycle as the request (pred_valid follows req_valid). A same-cycle update takes effect only from the next cycle.
- R11: Counter training uses the history values returned with the update (upd_lhist, upd_ghist), not the current histories.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request valid |
| req_pc | input | 32 | Fetch PC of the branch to predict |
| pred_valid | output | 1 | Lookup response valid |
| pred_taken | output | 1 | Final direction, 1 = taken |
| pred_local | output | 1 | Local-history component guess |
| pred_global | output | 1 | Global-history component guess |
| pred_lhist | output | 3 | Local history used for the lookup |
| pred_ghist | output | 3 | Global history used for the lookup |
| upd_valid | input | 1 | Resolved-branch update valid |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_local_pred | input | 1 | Local guess returned with the branch |
| upd_global_pred | input | 1 | Global guess returned with the branch |
| upd_lhist | input | 3 | Local history returned with the branch |
| upd_ghist | input | 3 | Global history returned with the branch |

## Verification
A single branch that flips every time shows whether the private history can learn a pattern that a counter alone cannot. A branch that is always taken drives counters into saturation and checks that they stop there. Lookups with the same low PC bits but different high bits show that the upper PC bits do not affect the result. A long mixed stream of many branches, with updates that arrive several lookups late, makes the component guesses disagree often, which exercises the chooser, and shows whether training really uses the captured indices rather than the live histories.

// File: rtl/bpred_pkg.sv
package bpred_pkg;
  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_WEAK_LOW = 2'b01;

  // saturating one-step move of a 2-bit counter
  function automatic ctr2_t ctr_step(input ctr2_t c, input logic up);
    ctr2_t n;
    if (up) n = (c == 2'b11) ? c : c + 2'b01;
    else    n = (c == 2'b00) ? c : c - 2'b01;
    return n;
  endfunction
endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
  import bpred_pkg::*;
#(
  parameter int    IDX_W = 3,
  parameter ctr2_t INIT  = CTR_WEAK_LOW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr2_t            rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;

  ctr2_t cells [DEPTH];

  assign rd_ctr = cells[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= INIT;
    end else if (wr_en) begin
      cells[wr_idx] <= ctr_step(cells[wr_idx], wr_up);
    end
  end
endmodule

// File: rtl/bp_hist_table.sv
module bp_hist_table #(
  parameter int IDX_W  = 3,
  parameter int HIST_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [HIST_W-1:0] rd_hist,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] slots [DEPTH];

  assign rd_hist = slots[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else if (wr_en) begin
      slots[wr_idx] <= {slots[wr_idx][HIST_W-2:0], wr_bit};
    end
  end
endmodule

// File: rtl/tourney_bp.sv
module tourney_bp
  import bpred_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int SLOT_W  = 3,
  parameter int LHIST_W = 3,
  parameter int GHIST_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [PC_W-1:0]    req_pc,
  output logic               pred_valid,
  output logic               pred_taken,
  output logic               pred_local,
  output logic               pred_global,
  output logic [LHIST_W-1:0] pred_lhist,
  output logic [GHIST_W-1:0] pred_ghist,
  input  logic               upd_valid,
  input  logic [PC_W-1:0]    upd_pc,
  input  logic               upd_taken,
  input  logic               upd_local_pred,
  input  logic               upd_global_pred,
  input  logic [LHIST_W-1:0] upd_lhist,
  input  logic [GHIST_W-1:0] upd_ghist
);
  localparam int SLOT_LO = 2;
  localparam int SLOT_HI = SLOT_LO + SLOT_W - 1;

  logic [SLOT_W-1:0]  req_slot, upd_slot;
  logic [LHIST_W-1:0] lhist_rd;
  logic [GHIST_W-1:0] ghr_q;
  ctr2_t              lctr, gctr, cctr;
  logic               chooser_wr;

  assign req_slot = req_pc[SLOT_HI:SLOT_LO];
  assign upd_slot = upd_pc[SLOT_HI:SLOT_LO];

  logic unused_pc_bits;
  assign unused_pc_bits = ^{req_pc[PC_W-1:SLOT_HI+1], req_pc[SLOT_LO-1:0],
                            upd_pc[PC_W-1:SLOT_HI+1], upd_pc[SLOT_LO-1:0],
                            cctr[0], lctr[0], gctr[0]};

  // per-slot outcome history
  bp_hist_table #(.IDX_W(SLOT_W), .HIST_W(LHIST_W)) u_lhist (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(req_slot), .rd_hist(lhist_rd),
    .wr_en(upd_valid), .wr_idx(upd_slot), .wr_bit(upd_taken)
  );

  // counters selected by per-slot history (trained at the captured history)
  bp_ctr_table #(.IDX_W(LHIST_W), .INIT(CTR_WEAK_LOW)) u_lpht (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lhist_rd), .rd_ctr(lctr),
    .wr_en(upd_valid), .wr_idx(upd_lhist), .wr_up(upd_taken)
  );

  // counters selected by shared history
  bp_ctr_table #(.IDX_W(GHIST_W), .INIT(CTR_WEAK_LOW)) u_gpht (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(ghr_q), .rd_ctr(gctr),
    .wr_en(upd_valid), .wr_idx(upd_ghist), .wr_up(upd_taken)
  );

  // chooser: trains only on disagreement, upward when the global guess was right
  assign chooser_wr = upd_valid && (upd_local_pred != upd_global_pred);

  bp_ctr_table #(.IDX_W(SLOT_W), .INIT(CTR_WEAK_LOW)) u_chooser (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(req_slot), .rd_ctr(cctr),
    .wr_en(chooser_wr), .wr_idx(upd_slot), .wr_up(upd_global_pred == upd_taken)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ghr_q <= '0;
    else if (upd_valid) ghr_q <= {ghr_q[GHIST_W-2:0], upd_taken};
  end

  assign pred_valid  = req_valid;
  assign pred_local  = lctr[1];
  assign pred_global = gctr[1];
  assign pred_taken  = cctr[1] ? gctr[1] : lctr[1];
  assign pred_lhist  = lhist_rd;
  assign pred_ghist  = ghr_q;
endmodule

// File: rtl/tourney_bp_checker.sv
module tourney_bp_checker #(
  parameter int PC_W    = 32,
  parameter int SLOT_W  = 3,
  parameter int LHIST_W = 3,
  parameter int GHIST_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [PC_W-1:0]    req_pc,
  input logic               pred_taken,
  input logic               pred_local,
  input logic               pred_global,
  input logic [LHIST_W-1:0] pred_lhist,
  input logic [GHIST_W-1:0] pred_ghist,
  input logic               upd_valid,
  input logic [PC_W-1:0]    upd_pc,
  input logic               upd_taken
);
  localparam int SLOT_LO = 2;
  localparam int SLOT_HI = SLOT_LO + SLOT_W - 1;

  p_agree_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pred_local == pred_global) |-> pred_taken == pred_local);

  p_ghist_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> pred_ghist == {$past(pred_ghist[GHIST_W-2:0]), $past(upd_taken)});

  p_ghist_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(pred_ghist));

  p_lhist_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (req_pc[SLOT_HI:SLOT_LO] != $past(upd_pc[SLOT_HI:SLOT_LO]))
                  || (pred_lhist[0] == $past(upd_taken)));
endmodule

bind tourney_bp tourney_bp_checker #(
  .PC_W(PC_W), .SLOT_W(SLOT_W), .LHIST_W(LHIST_W), .GHIST_W(GHIST_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pc(req_pc),
  .pred_taken(pred_taken), .pred_local(pred_local), .pred_global(pred_global),
  .pred_lhist(pred_lhist), .pred_ghist(pred_ghist),
  .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
);

// File: tb/tourney_bp_test.sv
module tourney_bp_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_pc = '0;
  logic        pred_valid, pred_taken, pred_local, pred_global;
  logic [2:0]  pred_lhist, pred_ghist;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic        upd_local_pred = 1'b0;
  logic        upd_global_pred = 1'b0;
  logic [2:0]  upd_lhist = '0;
  logic [2:0]  upd_ghist = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tourney_bp uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pc(req_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_local(pred_local),
    .pred_global(pred_global), .pred_lhist(pred_lhist), .pred_ghist(pred_ghist),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_local_pred(upd_local_pred), .upd_global_pred(upd_global_pred),
    .upd_lhist(upd_lhist), .upd_ghist(upd_ghist)
  );

  typedef struct {
    logic [31:0] pc;
    bit          lp;
    bit          gp;
    int          lh;
    int          gh;
  } rec_t;

  // behavioural reference state
  int m_lht[8];
  int m_lpht[8];
  int m_gpht[8];
  int m_cho[8];
  int m_ghr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  rec_t last;
  rec_t pend[$];

  function automatic int sat(input int c, input bit up);
    if (up) return (c < 3) ? c + 1 : 3;
    return (c > 0) ? c - 1 : 0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin
      m_lht[i] = 0; m_lpht[i] = 1; m_gpht[i] = 1; m_cho[i] = 1;
    end
    m_ghr = 0;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive lookup (+ optional update), compare outputs, advance model
  task automatic cycle(input logic [31:0] pc, input bit uv, input bit self_upd,
                       input rec_t u, input bit ut, input string tag);
    rec_t p, ur;
    int idx;
    bit exp_t;
    idx   = int'((pc >> 2) & 32'd7);
    p.pc  = pc;
    p.lh  = m_lht[idx];
    p.gh  = m_ghr;
    p.lp  = m_lpht[p.lh] >= 2;
    p.gp  = m_gpht[p.gh] >= 2;
    exp_t = (m_cho[idx] >= 2) ? p.gp : p.lp;
    ur    = self_upd ? p : u;
    @(negedge clk);
    req_valid = 1'b1; req_pc = pc;
    upd_valid = uv; upd_pc = ur.pc; upd_taken = ut;
    upd_local_pred = ur.lp; upd_global_pred = ur.gp;
    upd_lhist = 3'(ur.lh); upd_ghist = 3'(ur.gh);
    #1;
    check({"R10 ", tag}, 32'(pred_valid), 32'd1);
    check({"R5 ", tag}, 32'(pred_taken), 32'(exp_t));
    check({"R3 ", tag}, 32'(pred_local), 32'(p.lp));
    check({"R4 ", tag}, 32'(pred_global), 32'(p.gp));
    check({"R7 ", tag}, 32'(pred_lhist), 32'(p.lh));
    check({"R8 ", tag}, 32'(pred_ghist), 32'(p.gh));
    last = p;
    if (uv) begin
      int ui;
      ui = int'((ur.pc >> 2) & 32'd7);
      m_lpht[ur.lh] = sat(m_lpht[ur.lh], ut);          // R6, R11
      m_gpht[ur.gh] = sat(m_gpht[ur.gh], ut);
      if (ur.lp != ur.gp) m_cho[ui] = sat(m_cho[ui], ur.gp == ut);   // R9
      m_lht[ui] = ((m_lht[ui] << 1) | int'(ut)) & 7;
      m_ghr     = ((m_ghr << 1) | int'(ut)) & 7;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rec_t none;
    logic [2:0] lh_a;
    logic       t_a;
    none = '{pc: 32'd0, lp: 1'b0, gp: 1'b0, lh: 0, gh: 0};
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state seen from every slot
    for (int i = 0; i < 8; i++) begin
      cycle(32'h100 + 32'(i * 4), 1'b0, 1'b0, none, 1'b0, "reset");
      check("R1 taken", 32'(pred_taken), 32'd0);
      check("R1 local", 32'(pred_local), 32'd0);
      check("R1 global", 32'(pred_global), 32'd0);
      check("R1 lhist", 32'(pred_lhist), 32'd0);
      check("R1 ghist", 32'(pred_ghist), 32'd0);
    end

    // flip-flop branch: local history must learn the alternation (R3)
    for (int i = 0; i < 48; i++) begin
      cycle(32'h104, 1'b1, 1'b1, none, bit'(i % 2), "flip");
      if (i >= 40) check("R3 flip learned", 32'(pred_local), 32'(i % 2));
    end

    // always-taken branch drives counters to saturation and holds (R6)
    for (int i = 0; i < 12; i++)
      cycle(32'h108, 1'b1, 1'b1, none, 1'b1, "sat-up");
    check("R6 saturated taken", 32'(pred_local), 32'd1);
    for (int i = 0; i < 2; i++)
      cycle(32'h108, 1'b1, 1'b1, none, 1'b0, "sat-down");

    // R2: upper PC bits do not select anything
    cycle(32'h0000_0104, 1'b0, 1'b0, none, 1'b0, "R2 low");
    lh_a = pred_lhist; t_a = pred_taken;
    cycle(32'hABC0_0104, 1'b0, 1'b0, none, 1'b0, "R2 high");
    check("R2 lhist alias", 32'(pred_lhist), 32'(lh_a));
    check("R2 taken alias", 32'(pred_taken), 32'(t_a));

    // mixed stream with late updates carrying captured histories (R9, R11)
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] pc;
      bit uv, ut;
      rec_t u;
      pc = {$urandom(), 2'b00} ;
      pc = {pc[31:5] & 27'h3, pc[4:0]};
      uv = 1'b0; u = none; ut = 1'b0;
      if (pend.size() > 4 || (pend.size() > 0 && ($urandom() % 3) != 0)) begin
        u  = pend.pop_front();
        uv = 1'b1;
        ut = (u.pc[2] ^ u.pc[4]) ? 1'b1 : (($urandom() % 4) == 0);
        if (u.pc[3] && u.pc[2]) ut = bit'(u.gh & 1);
      end
      cycle(pc, uv, 1'b0, u, ut, "R11 late");
      pend.push_back(last);
    end

    @(negedge clk);
    req_valid = 1'b0; upd_valid = 1'b0;
    #1;
    check("R10 idle valid", 32'(pred_valid), 32'd0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule